// File: doc/BRIEF.md
# Dual-Plane Busy Status Generator

This block sits on the read path of a two-plane flash array. Command-decoding logic reports each embedded operation to it as a one-cycle event: program start, sector erase start, chip erase start, erase suspend, erase resume and operation done. An event carries an address, and the block maps that address to a plane and a sector. For each plane it keeps the state needed to answer host reads while the plane is working. This state is the busy flag, the kind of operation, the polling bit derived from the word being programmed, the running-toggle bit, the suspended sector, and the suspended-sector toggle bit.

On every host read strobe the block finds the plane and sector of the read address. It then returns one of three things one cycle later:
- the array word supplied alongside the read, unchanged;
- a busy status word, when the addressed plane is busy;
- a suspend status word, when the read targets the erase-suspended sector.

An active-low open-drain busy line is pulled low while any plane is busy. It is left floating otherwise, so an external pull-up restores it to 1.

Event codes on `ev_code` are: 1 program start, 2 sector erase start, 3 chip erase start, 4 erase suspend, 5 erase resume, 6 operation done. Any other code does nothing.

The address map is 20 bits of word address. `addr[19:18]==0` selects plane A, and any other value selects plane B. Plane A holds these sectors:
- sectors 0..7: 4K words each, from word 0;
- sectors 8..9: 16K words each, from word 0x8000;
- sectors 10..15: 32K words each, from word 0x10000.

Plane B holds sectors 16..39, each 32K words.

Top module: `busy_status_gen`

## Requirements
- R1: After reset no plane is busy, `rd_valid` is 0 and `rdy_busy_n` is not driven.
- R2: A read strobe causes `rd_valid` to be 1 in the following cycle only. If the addressed plane is neither busy nor targeting its suspended sector, `rd_data` then equals the `arr_data` given with the strobe.
- R3: While a program (code 1) runs in a plane, a read of that plane returns bit 7 equal to the inverse of `prog_d7` sampled at the start event. Every bit other than 7 and 6 is 0.
- R4: After an operation starts, the first read of the busy plane returns bit 6 = 0. Each further read of that plane returns the inverse of the previous one.
- R5: A read of the plane that is not busy returns array data (R2) and does not change the busy plane's bit 6 sequence.
- R6: `rdy_busy_n` is driven 0 from the cycle after a start event until the cycle after the done event (code 6) for that plane. It is undriven whenever no plane is busy.
- R7: While a sector erase (code 2) or chip erase (code 3) runs, a busy read returns bit 7 = 0.
- R8: The bit 6 toggle holds its value between reads and is cleared when the operation ends, is suspended or restarts.
- R9: Suspend (code 4) on a plane running a sector erase makes the plane not busy. Reads of the suspended sector then return a word whose bit 2 starts at 0 and inverts on each read or write strobe to that sector, with all other bits 0. Other sectors of the plane return array data.
- R10: Sector boundaries follow the map above; for example, words 0xBFFF, 0xC000..0xFFFF and 0x10000 lie in sectors 8, 9 and 10.
- R11: Chip erase makes both planes busy, and a done event on either plane ends it on both. Suspend is ignored while a chip erase runs.
- R12: Resume (code 5) makes a suspended plane busy with erase status again, with bit 6 restarting at 0, and drops the suspended sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Operation event strobe |
| ev_code | input | 3 | Event code (see R3, R7, R9, R11, R12) |
| ev_addr | input | 20 | Word address selecting plane and sector of the event |
| prog_d7 | input | 1 | Bit 7 of the word being programmed, used with code 1 |
| rd_stb | input | 1 | Host read strobe |
| rd_addr | input | 20 | Host read word address |
| arr_data | input | 16 | Array data for the read address |
| wr_stb | input | 1 | Host program attempt strobe |
| wr_addr | input | 20 | Host program attempt address |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Read result |
| rdy_busy_n | output | 1 | Open-drain busy, 0 when busy, floating otherwise |

## Verification
The bench interleaves reads of both planes during a program. A design that advanced the toggle on any read, rather than on reads of the busy plane only, would break the 0,1,0 bit 6 sequence. It probes both sides of the 16K/32K sector boundaries around a suspended sector, where an off-by-one sector decode would return status for a neighbour or array data for the suspended sector itself. A write strobe is placed between suspended-sector reads so that a design ignoring program attempts shows the wrong bit 2. The chip-erase case ends the erase with a done on plane B only, which catches a design that leaves plane A busy, and it sends a suspend that must be ignored.

// File: rtl/busy_status_pkg.sv
package busy_status_pkg;

  localparam int SEC_W       = 6;
  localparam int POLL_POS    = 7;
  localparam int RUN_TOG_POS = 6;
  localparam int SUS_TOG_POS = 2;

  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_PROG    = 3'd1,
    EV_SERASE  = 3'd2,
    EV_CERASE  = 3'd3,
    EV_SUSPEND = 3'd4,
    EV_RESUME  = 3'd5,
    EV_DONE    = 3'd6
  } ev_code_e;

endpackage

// File: rtl/sector_map.sv
module sector_map
  import busy_status_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              plane,
  output logic [SEC_W-1:0]  sector
);

  localparam int BIG_W   = 3;
  localparam int BIG_LSB = ADDR_W - 2 - BIG_W;
  localparam int MID_BIT = BIG_LSB - 1;
  localparam int SML_LSB = BIG_LSB - 3;
  localparam int B_W     = 2 + BIG_W;

  logic [1:0]       quarter;
  logic [BIG_W-1:0] big_idx;
  logic [B_W-1:0]   b_idx;
  logic             unused_low;

  assign quarter    = addr[ADDR_W-1 -: 2];
  assign big_idx    = addr[BIG_LSB +: BIG_W];
  assign b_idx      = addr[ADDR_W-1 -: B_W];
  assign unused_low = ^addr[SML_LSB-1:0];

  always_comb begin
    plane  = (quarter != 2'b00);
    sector = '0;
    if (plane) begin
      sector = SEC_W'(b_idx) + SEC_W'(8);
    end else if (big_idx >= BIG_W'(2)) begin
      sector = SEC_W'(big_idx) + SEC_W'(8);
    end else if (big_idx == BIG_W'(1)) begin
      sector = SEC_W'(8) + SEC_W'(addr[MID_BIT]);
    end else begin
      sector = SEC_W'(addr[SML_LSB +: 3]);
    end
  end

endmodule

// File: rtl/plane_tracker.sv
module plane_tracker
  import busy_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic             ev_hit,
  input  ev_code_e         ev_code,
  input  logic [SEC_W-1:0] ev_sector,
  input  logic             prog_d7,
  input  logic             chip_end,
  input  logic             rd_hit,
  input  logic [SEC_W-1:0] rd_sector,
  input  logic             wr_hit,
  input  logic [SEC_W-1:0] wr_sector,
  output logic             busy,
  output logic             chip,
  output logic             poll,
  output logic             run_tog,
  output logic             susp,
  output logic [SEC_W-1:0] susp_sector,
  output logic             sus_tog
);

  logic             busy_q, busy_n;
  logic             erase_q, erase_n;
  logic             chip_q, chip_n;
  logic             poll_q, poll_n;
  logic             tog_q, tog_n;
  logic             susp_q, susp_n;
  logic             stog_q, stog_n;
  logic [SEC_W-1:0] er_sec_q, er_sec_n;
  logic [SEC_W-1:0] sus_sec_q, sus_sec_n;
  logic             sus_touch;

  assign sus_touch = susp_q &&
                     ((rd_hit && rd_sector == sus_sec_q) ||
                      (wr_hit && wr_sector == sus_sec_q));

  always_comb begin
    busy_n    = busy_q;
    erase_n   = erase_q;
    chip_n    = chip_q;
    poll_n    = poll_q;
    tog_n     = tog_q;
    susp_n    = susp_q;
    stog_n    = stog_q;
    er_sec_n  = er_sec_q;
    sus_sec_n = sus_sec_q;
    if (busy_q && rd_hit) tog_n = ~tog_q;
    if (sus_touch)        stog_n = ~stog_q;
    if (ev_valid) begin
      unique case (ev_code)
        EV_PROG: if (ev_hit) begin
          busy_n = 1'b1; erase_n = 1'b0; chip_n = 1'b0;
          poll_n = ~prog_d7; tog_n = 1'b0;
        end
        EV_SERASE: if (ev_hit) begin
          busy_n = 1'b1; erase_n = 1'b1; chip_n = 1'b0;
          poll_n = 1'b0; tog_n = 1'b0; er_sec_n = ev_sector;
        end
        EV_CERASE: begin
          busy_n = 1'b1; erase_n = 1'b1; chip_n = 1'b1;
          poll_n = 1'b0; tog_n = 1'b0;
        end
        EV_SUSPEND: if (ev_hit && busy_q && erase_q && !chip_q) begin
          busy_n = 1'b0; susp_n = 1'b1; sus_sec_n = er_sec_q;
          stog_n = 1'b0; tog_n = 1'b0;
        end
        EV_RESUME: if (ev_hit && susp_q && !busy_q) begin
          busy_n = 1'b1; erase_n = 1'b1; chip_n = 1'b0; poll_n = 1'b0;
          susp_n = 1'b0; stog_n = 1'b0; tog_n = 1'b0;
        end
        EV_DONE: if (ev_hit || (chip_q && chip_end)) begin
          busy_n = 1'b0; chip_n = 1'b0; tog_n = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      erase_q   <= 1'b0;
      chip_q    <= 1'b0;
      poll_q    <= 1'b0;
      tog_q     <= 1'b0;
      susp_q    <= 1'b0;
      stog_q    <= 1'b0;
      er_sec_q  <= '0;
      sus_sec_q <= '0;
    end else begin
      busy_q    <= busy_n;
      erase_q   <= erase_n;
      chip_q    <= chip_n;
      poll_q    <= poll_n;
      tog_q     <= tog_n;
      susp_q    <= susp_n;
      stog_q    <= stog_n;
      er_sec_q  <= er_sec_n;
      sus_sec_q <= sus_sec_n;
    end
  end

  assign busy        = busy_q;
  assign chip        = chip_q;
  assign poll        = poll_q;
  assign run_tog     = tog_q;
  assign susp        = susp_q;
  assign susp_sector = sus_sec_q;
  assign sus_tog     = stog_q;

  AST_START_TOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !tog_q); // R4
  AST_IDLE_TOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !tog_q); // R8
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rd_hit && !ev_valid) |=> $stable(tog_q)); // R8
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == EV_DONE && ev_hit) |=> !busy_q); // R6
  AST_SUSP_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> !(busy_q && erase_q)); // R9
  AST_CHIP_NO_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    chip_q |=> !$rose(susp_q)); // R11

endmodule

// File: rtl/status_mux.sv
module status_mux
  import busy_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [1:0]            busy,
  input  logic [1:0]            poll,
  input  logic [1:0]            run_tog,
  input  logic [1:0]            susp,
  input  logic [1:0][SEC_W-1:0] susp_sector,
  input  logic [1:0]            sus_tog,
  input  logic                  rd_plane,
  input  logic [SEC_W-1:0]      rd_sector,
  input  logic [DATA_W-1:0]     arr_data,
  output logic [DATA_W-1:0]     data_out
);

  always_comb begin
    data_out = arr_data;
    if (busy[rd_plane]) begin
      data_out              = '0;
      data_out[POLL_POS]    = poll[rd_plane];
      data_out[RUN_TOG_POS] = run_tog[rd_plane];
    end else if (susp[rd_plane] && susp_sector[rd_plane] == rd_sector) begin
      data_out              = '0;
      data_out[SUS_TOG_POS] = sus_tog[rd_plane];
    end
  end

endmodule

// File: rtl/busy_status_gen.sv
module busy_status_gen
  import busy_status_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [2:0]        ev_code,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              prog_d7,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output wire               rdy_busy_n
);

  localparam int PLANES = 2;

  logic             ev_plane, rd_plane, wr_plane;
  logic [SEC_W-1:0] ev_sector, rd_sector, wr_sector;
  ev_code_e         ev_kind;
  logic             chip_end;

  logic [PLANES-1:0]            busy, chip, poll, run_tog, susp, sus_tog;
  logic [PLANES-1:0][SEC_W-1:0] susp_sector;

  logic [DATA_W-1:0] mux_data;
  logic              rd_valid_q, rd_valid_n;
  logic [DATA_W-1:0] rd_data_q, rd_data_n;

  assign ev_kind  = ev_code_e'(ev_code);
  assign chip_end = ev_valid && (ev_kind == EV_DONE) && chip[ev_plane];

  sector_map #(.ADDR_W(ADDR_W)) i_ev_map (
    .addr(ev_addr), .plane(ev_plane), .sector(ev_sector));
  sector_map #(.ADDR_W(ADDR_W)) i_rd_map (
    .addr(rd_addr), .plane(rd_plane), .sector(rd_sector));
  sector_map #(.ADDR_W(ADDR_W)) i_wr_map (
    .addr(wr_addr), .plane(wr_plane), .sector(wr_sector));

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    plane_tracker i_tracker (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_valid   (ev_valid),
      .ev_hit     (ev_valid && (ev_plane == 1'(p))),
      .ev_code    (ev_kind),
      .ev_sector  (ev_sector),
      .prog_d7    (prog_d7),
      .chip_end   (chip_end),
      .rd_hit     (rd_stb && (rd_plane == 1'(p))),
      .rd_sector  (rd_sector),
      .wr_hit     (wr_stb && (wr_plane == 1'(p))),
      .wr_sector  (wr_sector),
      .busy       (busy[p]),
      .chip       (chip[p]),
      .poll       (poll[p]),
      .run_tog    (run_tog[p]),
      .susp       (susp[p]),
      .susp_sector(susp_sector[p]),
      .sus_tog    (sus_tog[p])
    );
  end

  status_mux #(.DATA_W(DATA_W)) i_mux (
    .busy       (busy),
    .poll       (poll),
    .run_tog    (run_tog),
    .susp       (susp),
    .susp_sector(susp_sector),
    .sus_tog    (sus_tog),
    .rd_plane   (rd_plane),
    .rd_sector  (rd_sector),
    .arr_data   (arr_data),
    .data_out   (mux_data)
  );

  always_comb begin
    rd_valid_n = rd_stb;
    rd_data_n  = rd_data_q;
    if (rd_stb) rd_data_n = mux_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_valid_n;
      rd_data_q  <= rd_data_n;
    end
  end

  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;
  assign rdy_busy_n = (|busy) ? 1'b0 : 1'bz;

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid); // R2
  AST_CHIP_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == EV_CERASE) |=> (&busy)); // R11

endmodule

// File: tb/test_busy_status_gen.sv
module test_busy_status_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_code = 3'd0;
  logic [19:0] ev_addr = '0;
  logic        prog_d7 = 1'b0;
  logic        rd_stb = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [15:0] arr_data = '0;
  logic        wr_stb = 1'b0;
  logic [19:0] wr_addr = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  wire         rb_n;

  pullup (rb_n);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  busy_status_gen i_busy_status_gen (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_addr(ev_addr), .prog_d7(prog_d7), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .arr_data(arr_data), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rdy_busy_n(rb_n));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic event_op(input logic [2:0] code, input logic [19:0] a, input logic d7);
    @(negedge clk);
    ev_valid = 1'b1; ev_code = code; ev_addr = a; prog_d7 = d7;
    @(negedge clk);
    ev_valid = 1'b0; ev_code = 3'd0;
  endtask

  task automatic read_chk(input string req, input logic [19:0] a,
                          input logic [15:0] arr, input logic [15:0] exp);
    @(negedge clk);
    rd_stb = 1'b1; rd_addr = a; arr_data = arr;
    @(negedge clk);
    rd_stb = 1'b0;
    check({req, " valid"}, 16'(rd_valid), 16'h1);
    check(req, rd_data, exp);
  endtask

  task automatic write_pulse(input logic [19:0] a);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rd_valid", 16'(rd_valid), 16'h0);
    check("R1 busy line", 16'(rb_n), 16'h1);
    read_chk("R1 idle plane B", 20'h9_0000, 16'hA5A5, 16'hA5A5);
  endtask

  task automatic t_idle();
    read_chk("R2 passthrough", 20'h0_1234, 16'hBEEF, 16'hBEEF);
    @(negedge clk);
    check("R2 valid one cycle", 16'(rd_valid), 16'h0);
  endtask

  task automatic t_program();
    event_op(3'd1, 20'h5_0000, 1'b0);
    check("R6 busy low", 16'(rb_n), 16'h0);
    read_chk("R3 R4 first read", 20'h5_0010, 16'hFFFF, 16'h0080);
    read_chk("R5 other plane", 20'h0_0100, 16'h1234, 16'h1234);
    read_chk("R4 R5 second read", 20'h5_0010, 16'hFFFF, 16'h00C0);
    read_chk("R4 third read", 20'h4_0000, 16'h0000, 16'h0080);
    event_op(3'd6, 20'h5_0000, 1'b0);
    check("R6 released", 16'(rb_n), 16'h1);
    read_chk("R2 after done", 20'h5_0010, 16'h5A5A, 16'h5A5A);
    event_op(3'd1, 20'h7_0000, 1'b1);
    read_chk("R8 R3 restart", 20'h7_0000, 16'hFFFF, 16'h0000);
    event_op(3'd6, 20'h7_0000, 1'b0);
  endtask

  task automatic t_erase_suspend();
    event_op(3'd2, 20'h0_C123, 1'b0);
    read_chk("R7 erase poll", 20'h0_C000, 16'hFFFF, 16'h0000);
    read_chk("R7 R4 erase toggle", 20'h0_C000, 16'hFFFF, 16'h0040);
    event_op(3'd4, 20'h0_0000, 1'b0);
    check("R9 suspend frees line", 16'(rb_n), 16'h1);
    read_chk("R9 R10 top of sector", 20'h0_FFFF, 16'h7777, 16'h0000);
    read_chk("R9 second", 20'h0_C000, 16'h7777, 16'h0004);
    read_chk("R10 next sector", 20'h1_0000, 16'h1111, 16'h1111);
    read_chk("R10 previous sector", 20'h0_BFFF, 16'h2222, 16'h2222);
    write_pulse(20'h0_D000);
    read_chk("R9 after program attempt", 20'h0_C000, 16'h7777, 16'h0004);
    read_chk("R5 plane B while suspended", 20'h8_0000, 16'h6666, 16'h6666);
    event_op(3'd5, 20'h0_0000, 1'b0);
    check("R12 busy again", 16'(rb_n), 16'h0);
    read_chk("R12 resumed status", 20'h0_C000, 16'hFFFF, 16'h0000);
    event_op(3'd6, 20'h0_0000, 1'b0);
    read_chk("R12 sector released", 20'h0_C000, 16'h3333, 16'h3333);
  endtask

  task automatic t_chip();
    event_op(3'd3, 20'h0_0000, 1'b0);
    check("R11 busy", 16'(rb_n), 16'h0);
    read_chk("R11 plane A", 20'h0_0000, 16'hFFFF, 16'h0000);
    read_chk("R11 plane B", 20'hF_0000, 16'hFFFF, 16'h0000);
    read_chk("R11 R7 plane B toggle", 20'hF_0000, 16'hFFFF, 16'h0040);
    event_op(3'd4, 20'h0_0000, 1'b0);
    read_chk("R11 suspend ignored", 20'h0_0000, 16'hFFFF, 16'h0040);
    event_op(3'd6, 20'h9_0000, 1'b0);
    check("R11 both released", 16'(rb_n), 16'h1);
    read_chk("R11 plane A free", 20'h0_0000, 16'h4444, 16'h4444);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_program();
    t_erase_suspend();
    t_chip();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule